// File: doc/BRIEF.md
# Reverse-Order CRC-16 Accumulator

This block computes a CRC-16 (generator x^16 + x^12 + x^5 + 1, zero initial value, no reflection, no final inversion) over a message whose bytes are handed to it starting from the final byte and working back to the first. It does not feed any padding zeros. Each byte is treated as the leading byte of a string followed by as many zero bytes as were already delivered. The block keeps a running multiplier equal to x^(8·(n+1)) modulo the generator and folds each byte in with a carry-less multiply reduced modulo the generator. The XOR of all these per-byte terms equals the CRC of the whole message taken in forward order.

A client pulses `start` to begin a message. It then offers bytes with `in_valid` whenever `in_ready` is high and marks the first message byte, which is the last one delivered, with `in_last`. Each byte takes three cycles. The first cycle accepts it, the second advances the multiplier, and the third adds the byte's term into the CRC. The two reductions per byte share one modular multiplier by default. A parameter can instead give each its own multiplier. After the marked byte, `done` pulses once and the result stays on `crc_out` until the next `start`.

Top module: `rev_crc16_acc`

## Requirements
- R1: After the asynchronous active-low reset, `crc_out` is 0x0000, `done` is 0 and `in_ready` is 1.
- R2: A `start` sampled high at a clock edge, in any state, sets the CRC to 0 and the running multiplier back to x^8 (0x0100). From the next cycle `in_ready` is 1 and `done` is 0. A byte offered in the same cycle as `start` is discarded.
- R3: For each accepted byte, the running multiplier M is first replaced by (x^8 · M) mod G, where G is 0x1021 with the implicit x^16 term. This happens in the cycle after acceptance.
- R4: In the following cycle the CRC becomes CRC XOR ((byte · M) mod G), using the updated M. The new value appears on `crc_out` two clock edges after the edge that accepted the byte. `crc_out` changes at no other edge except a `start`.
- R5: When bytes are delivered last-first, `crc_out` after each byte equals the forward MSB-first CRC-16 (G = 0x1021, init 0, no final XOR) of the message suffix delivered so far. After the final byte, it equals the CRC of the whole message.
- R6: A byte accepted with `in_last` = 1 makes `done` high for exactly one cycle. That cycle is the first one in which the final CRC is visible.
- R7: After `done`, `crc_out` stays constant and `in_ready` stays 0 until `start`. Bytes offered in that period are ignored.
- R8: `in_ready` is 1 only while idle. A byte is accepted only when `in_valid` and `in_ready` are both 1. `in_ready` rises again in the cycle after a non-final byte is accumulated, so a new byte can be taken every three cycles. Bytes offered while `in_ready` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Synchronous clear of CRC and multiplier, returns to idle |
| in_valid | input | 1 | A byte is offered on `in_byte` |
| in_byte | input | 8 | Message byte, supplied last byte first |
| in_last | input | 1 | Marks the offered byte as the first byte of the message |
| in_ready | output | 1 | Block is idle and will take an offered byte |
| crc_out | output | 16 | Accumulated CRC |
| done | output | 1 | One-cycle pulse when the final CRC is available |

## Verification
The hardest situation to reach from the ports is a `start` that arrives while a byte is half-processed, after the multiplier has advanced but before the CRC term is added. Only a restart there shows whether both registers are really cleared. The stimulus aborts messages at randomly chosen points, with a byte offered in the same cycle as `start`. The reference model, which rebuilds the CRC of the suffix from a byte queue, then has to agree on the next message. Junk bytes are driven on every cycle in which `in_ready` is low, including the hold period after `done`, so that any wrongly accepted byte corrupts the compared CRC.

// File: rtl/rcrc_pkg.sv
package rcrc_pkg;
  // Sequencer phases of one byte: idle/accept, multiplier advance, CRC fold, result hold
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PAD  = 2'd1,
    ST_ACC  = 2'd2,
    ST_HOLD = 2'd3
  } rcrc_state_e;
endpackage

// File: rtl/rcrc_modmul.sv
// Carry-less multiply of two W-bit polynomials reduced modulo x^W + POLY.
// Reduction uses a precomputed reciprocal so that the quotient comes from
// two further carry-less products instead of a serial division.
module rcrc_modmul #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] res
);
  localparam int PW = 2*W - 1;

  // floor(x^(2W-1) / G), G = x^W + POLY
  function automatic logic [W-1:0] inv_poly();
    logic [W:0]   num;
    logic [W-1:0] q;
    num = (W+1)'(1) << W;
    q   = '0;
    for (int i = 0; i < W; i++) begin
      q = q << 1;
      if (num[W]) begin
        q[0] = 1'b1;
        num  = num ^ {1'b1, POLY};
      end
      num = num << 1;
    end
    return q;
  endfunction

  localparam logic [W-1:0] IPOLY = inv_poly();

  function automatic logic [W-1:0] mulmod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [PW-1:0] prod;
    logic [PW-1:0] qx;
    logic [W-1:0]  quo;
    logic [W-1:0]  fold;
    prod = '0;
    for (int i = 0; i < W; i++)
      if (a[i]) prod = prod ^ (PW'(b) << i);
    // quotient depends only on the upper W-1 product bits
    qx = '0;
    for (int i = 0; i < W-1; i++)
      if (prod[W+i]) qx = qx ^ (PW'(IPOLY) << i);
    quo = qx[PW-1:W-1];
    // only the low W bits of quo*G matter; the x^W term falls outside
    fold = '0;
    for (int i = 0; i < W; i++)
      if (quo[i]) fold = fold ^ (POLY << i);
    return prod[W-1:0] ^ fold;
  endfunction

  assign res = mulmod(op_a, op_b);
endmodule

// File: rtl/rcrc_ctrl.sv
module rcrc_ctrl
  import rcrc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic accept,
  output logic pad_step,
  output logic acc_step,
  output logic done
);
  rcrc_state_e state_q;
  logic        last_q;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_ready && in_valid && !start;
  assign pad_step = (state_q == ST_PAD) && !start;
  assign acc_step = (state_q == ST_ACC) && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      last_q  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state_q <= ST_IDLE;
        last_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (accept) begin
            state_q <= ST_PAD;
            last_q  <= in_last;
          end
          ST_PAD:  state_q <= ST_ACC;
          ST_ACC: begin
            state_q <= last_q ? ST_HOLD : ST_IDLE;
            done    <= last_q;
          end
          ST_HOLD: state_q <= ST_HOLD;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rcrc_datapath.sv
module rcrc_datapath #(
  parameter int               CRC_W     = 16,
  parameter int               DATA_W    = 8,
  parameter logic [CRC_W-1:0] POLY      = 16'h1021,
  parameter bit               SHARE_MUL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              accept,
  input  logic              pad_step,
  input  logic              acc_step,
  input  logic [DATA_W-1:0] in_byte,
  output logic [CRC_W-1:0]  crc_out
);
  // x^DATA_W: one byte of zero padding
  localparam logic [CRC_W-1:0] PAD_K = CRC_W'(1) << DATA_W;

  logic [DATA_W-1:0] byte_q;
  logic [CRC_W-1:0]  pdm_q;
  logic [CRC_W-1:0]  crc_q;
  logic [CRC_W-1:0]  pdm_next;
  logic [CRC_W-1:0]  term;

  generate
    if (SHARE_MUL) begin : g_shared
      logic [CRC_W-1:0] op_a;
      logic [CRC_W-1:0] mres;
      assign op_a = pad_step ? PAD_K : CRC_W'(byte_q);
      rcrc_modmul #(.W(CRC_W), .POLY(POLY)) u_mul (
        .op_a(op_a), .op_b(pdm_q), .res(mres)
      );
      assign pdm_next = mres;
      assign term     = mres;
    end else begin : g_dual
      rcrc_modmul #(.W(CRC_W), .POLY(POLY)) u_mul_pad (
        .op_a(PAD_K), .op_b(pdm_q), .res(pdm_next)
      );
      rcrc_modmul #(.W(CRC_W), .POLY(POLY)) u_mul_term (
        .op_a(CRC_W'(byte_q)), .op_b(pdm_q), .res(term)
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      pdm_q  <= PAD_K;
      crc_q  <= '0;
    end else if (start) begin
      pdm_q  <= PAD_K;
      crc_q  <= '0;
    end else begin
      if (accept)   byte_q <= in_byte;
      if (pad_step) pdm_q  <= pdm_next;
      if (acc_step) crc_q  <= crc_q ^ term;
    end
  end

  assign crc_out = crc_q;
endmodule

// File: rtl/rev_crc16_acc.sv
module rev_crc16_acc #(
  parameter int               CRC_W     = 16,
  parameter int               DATA_W    = 8,
  parameter logic [CRC_W-1:0] POLY      = 16'h1021,
  parameter bit               SHARE_MUL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_last,
  output logic              in_ready,
  output logic [CRC_W-1:0]  crc_out,
  output logic              done
);
  // named internal events, observed by the bound checker
  logic accept;
  logic pad_step;
  logic acc_step;

  rcrc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .accept   (accept),
    .pad_step (pad_step),
    .acc_step (acc_step),
    .done     (done)
  );

  rcrc_datapath #(
    .CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .SHARE_MUL(SHARE_MUL)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .accept   (accept),
    .pad_step (pad_step),
    .acc_step (acc_step),
    .in_byte  (in_byte),
    .crc_out  (crc_out)
  );
endmodule

// File: rtl/rcrc_checker.sv
module rcrc_checker #(
  parameter int CRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_ready,
  input logic             done,
  input logic [CRC_W-1:0] crc_out,
  input logic             accept,
  input logic             pad_step,
  input logic             acc_step
);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (crc_out == '0 && in_ready && !done));

  a_r3_advance_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pad_step || start));

  a_r4_fold_follows_advance: assert property (@(posedge clk) disable iff (!rst_n)
    acc_step |-> $past(pad_step));

  a_r4_crc_moves_only_on_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_step && !start) |=> $stable(crc_out));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_after_fold: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(acc_step));

  a_r7_no_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  a_r8_ready_or_done_after_fold: assert property (@(posedge clk) disable iff (!rst_n)
    acc_step |=> (in_ready ^ done));
endmodule

bind rev_crc16_acc rcrc_checker #(.CRC_W(CRC_W)) u_rcrc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .in_ready (in_ready),
  .done     (done),
  .crc_out  (crc_out),
  .accept   (accept),
  .pad_step (pad_step),
  .acc_step (acc_step)
);

// File: tb/test_rev_crc16_acc.sv
`timescale 1ns/1ps
module test_rev_crc16_acc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [15:0] crc_out;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  rev_crc16_acc i_rev_crc16_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_byte(in_byte), .in_last(in_last), .in_ready(in_ready),
    .crc_out(crc_out), .done(done)
  );

  // forward, MSB-first, bit-at-a-time CRC of a byte list
  function automatic logic [15:0] fwd_crc(input logic [7:0] q[$]);
    logic [15:0] c = 16'h0000;
    foreach (q[k]) begin
      c = c ^ {q[k], 8'h00};
      for (int b = 0; b < 8; b++)
        c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0]  m_suf[$];
  int          m_phase = 0;   // 0 idle, 1 advance, 2 fold, 3 hold
  logic [15:0] m_crc = 16'h0;
  logic        m_done = 1'b0;
  logic [7:0]  m_pend = 8'h0;
  logic        m_plast = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || start) begin
      m_suf.delete();
      m_phase = 0; m_crc = 16'h0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      case (m_phase)
        0: if (in_valid) begin m_pend = in_byte; m_plast = in_last; m_phase = 1; end
        1: m_phase = 2;
        2: begin
          m_suf.push_front(m_pend);
          m_crc   = fwd_crc(m_suf);
          m_done  = m_plast;
          m_phase = m_plast ? 3 : 0;
        end
        default: m_phase = 3;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_phase == 3 ? "R7 in_ready" : "R8 in_ready", 16'(in_ready), 16'(m_phase == 0));
      chk("R6 done", 16'(done), 16'(m_done));
      chk(m_phase == 3 ? "R7 crc hold" : "R4/R5 crc", crc_out, m_crc);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] msg_q[$];

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1; in_valid = 1'b1; in_byte = 8'($urandom); in_last = 1'($urandom);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    chk("R2 crc cleared", crc_out, 16'h0000);
    chk("R2 ready", 16'(in_ready), 16'h1);
    chk("R2 done low", 16'(done), 16'h0);
  endtask

  // feed msg_q last byte first; abort_after < 0 means run to completion
  task automatic feed(input int abort_after);
    int i = msg_q.size() - 1;
    int sent = 0;
    while (i >= 0) begin
      @(negedge clk);
      if (abort_after >= 0 && sent == abort_after) begin
        in_valid = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        start = 1'b1; in_valid = 1'b1; in_byte = 8'($urandom);
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
        chk("R2 abort clears", crc_out, 16'h0000);
        return;
      end
      if (in_ready) begin
        in_valid = 1'b1; in_byte = msg_q[i]; in_last = (i == 0);
        i--; sent++;
      end else begin
        in_valid = 1'($urandom); in_byte = 8'($urandom); in_last = 1'($urandom);
      end
    end
    // junk during the rest of the byte and the hold period
    repeat (8) begin
      @(negedge clk);
      in_valid = 1'b1; in_byte = 8'($urandom); in_last = 1'($urandom);
    end
    chk("R5 final crc", crc_out, fwd_crc(msg_q));
    chk("R7 ready low in hold", 16'(in_ready), 16'h0);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_msg(input int len, input int kind, input int abort_after);
    msg_q.delete();
    for (int k = 0; k < len; k++) begin
      case (kind)
        1: msg_q.push_back(8'h00);
        2: msg_q.push_back(8'hFF);
        3: msg_q.push_back(8'h31 + 8'(k % 9));
        default: msg_q.push_back(8'($urandom));
      endcase
    end
    pulse_start();
    feed(abort_after);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 crc reset", crc_out, 16'h0000);
    chk("R1 ready reset", 16'(in_ready), 16'h1);
    chk("R1 done reset", 16'(done), 16'h0);

    run_msg(1, 0, -1);          // single byte
    run_msg(18, 0, -1);         // 18 bytes
    run_msg(9, 3, -1);          // ascii digits
    run_msg(12, 1, -1);         // all zero
    run_msg(12, 2, -1);         // all ones
    run_msg(10, 0, 4);          // restart mid-message
    run_msg(5, 0, 0);           // restart right away
    run_msg(18, 0, -1);         // after restart
    for (int n = 0; n < 40; n++) begin
      int len = $urandom_range(1, 24);
      int ab  = ($urandom_range(0, 4) == 0) ? $urandom_range(0, len - 1) : -1;
      run_msg(len, 0, ab);
    end

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule